// File: doc/BRIEF.md
# Power-Fail Guarded Byte Memory Controller

This block sits between a host bus and a battery-backed byte array. The host drives two chip enables of opposite polarity, an active-low output enable and an active-low write enable. The block turns these levels into read, write and idle operations on an internal array of 2^ADDR_W bytes. With ADDR_W = 13 the array holds the full 8K bytes. The default is smaller so that elaboration stays small. The bus is level-controlled. There is no valid/ready pair and no back-pressure: a read returns data one clock later, and a write is committed when its pulse ends.

A digital power-good flag from an external comparator passes through a synchroniser before use. When the flag drops, the active-low interrupt asserts at once. The bus keeps working for a fixed warning window of DESEL_CYC clocks, and after that every access is refused. When the flag returns, the interrupt releases immediately. The bus then stays refused for RECOV_CYC clocks before normal service resumes. A reset places the block at the start of that recovery lockout.

At 125 MHz, a DESEL_CYC of 1250 to 5000 gives a warning window of 10 to 40 µs. A RECOV_CYC of 125000 gives a lockout of 1 ms.

Top module: `pfc_sram_guard`

## Requirements
- R1: When ce1_n is 1 or ce2 is 0 at a clock edge, that edge performs no read and no write, and dout_en is 0 after it, whatever oe_n and we_n are.
- R2: A write is active at an edge when ce1_n=0, ce2=1 and we_n=0; oe_n is ignored. The byte is committed at the first edge where the write is no longer active. It uses the address and data sampled at the last active edge.
- R3: A read at an edge (ce1_n=0, ce2=1, we_n=1, oe_n=0) sets dout_en=1 and dout to the stored byte after that edge. If oe_n=1 or we_n=0, dout_en is 0 after the edge.
- R4: pwr_good passes through a two-flop synchroniser; pfi_n goes to 0 right after the third rising edge that samples pwr_good low, starting from normal service.
- R5: After pfi_n falls, exactly DESEL_CYC further edges still serve accesses; from the next edge on, all accesses are refused.
- R6: While locked out, all bus inputs are ignored: dout_en stays 0 and no byte of the array changes.
- R7: A write whose pulse is still active when the lockout begins is discarded; its address keeps its old byte.
- R8: On the third edge that samples pwr_good high during lockout, pfi_n returns to 1. Accesses then stay refused for RECOV_CYC edges, and the next edge is served.
- R9: During and straight after reset, pfi_n is 1, dout_en is 0, and the recovery lockout of R8 runs with power presumed good.
- R10: If power returns during the warning window, the block enters the recovery lockout. If power fails during recovery, the block locks out at once with pfi_n 0 and no warning window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Asynchronous supply-above-threshold flag |
| ce1_n | input | 1 | Active-low chip enable |
| ce2 | input | 1 | Active-high chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data |
| dout_en | output | 1 | Drive enable for dout; 0 models high impedance |
| pfi_n | output | 1 | Active-low power-fail interrupt |

## Verification
Several properties are checked on every clock. Deselect, output enable and lockout each force dout_en low on the next cycle. No byte is committed while access is refused, and a held write is dropped at lockout. The warning window lasts exactly DESEL_CYC cycles, and pfi_n stays high throughout recovery. The bench scenarios cover what a single-cycle property cannot: trailing-edge commit of the last sampled byte, read-back of data across power events, and the synchroniser latency. They also measure the recovery length and exercise the glitch paths, with power lost during warning and during recovery.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic [1:0] {
    PS_RUN     = 2'd0,
    PS_WARN    = 2'd1,
    PS_LOCK    = 2'd2,
    PS_RECOVER = 2'd3
  } pstate_t;
endpackage

// File: rtl/pfc_sync.sv
module pfc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= {STAGES{RST_VAL}};
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/pfc_seq.sv
module pfc_seq
  import pfc_pkg::*;
#(
  parameter int DESEL_CYC = 2500,
  parameter int RECOV_CYC = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pg,
  output logic bus_ok,
  output logic locked,
  output logic pfi_n
);
  localparam int MAXC = (DESEL_CYC > RECOV_CYC) ? DESEL_CYC : RECOV_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  pstate_t        st;
  logic [CW-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= PS_RECOVER;
      cnt <= '0;
    end else begin
      case (st)
        PS_RUN: begin
          if (!pg) begin
            st  <= PS_WARN;
            cnt <= '0;
          end
        end
        PS_WARN: begin
          if (pg) begin
            st  <= PS_RECOVER;
            cnt <= '0;
          end else if (cnt == CW'(DESEL_CYC - 1)) begin
            st  <= PS_LOCK;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PS_LOCK: begin
          if (pg) begin
            st  <= PS_RECOVER;
            cnt <= '0;
          end
        end
        default: begin
          if (!pg) begin
            st  <= PS_LOCK;
            cnt <= '0;
          end else if (cnt == CW'(RECOV_CYC - 1)) begin
            st  <= PS_RUN;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign bus_ok = (st == PS_RUN) || (st == PS_WARN);
  assign locked = (st == PS_LOCK);
  assign pfi_n  = !((st == PS_WARN) || (st == PS_LOCK));
endmodule

// File: rtl/pfc_array.sv
module pfc_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_ok,
  input  logic          ce1_n,
  input  logic          ce2,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          wr_commit,
  output logic          wr_pend
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_data;
  logic          sel, wr_lvl, rd_now;

  assign sel       = !ce1_n && ce2;
  assign wr_lvl    = sel && !we_n;
  assign rd_now    = bus_ok && sel && we_n && !oe_n;
  assign wr_commit = bus_ok && wr_pend && !wr_lvl;

  // pending write: latest address/data of an active pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pend <= 1'b0;
      p_addr  <= '0;
      p_data  <= '0;
    end else if (bus_ok && wr_lvl) begin
      wr_pend <= 1'b1;
      p_addr  <= addr;
      p_data  <= din;
    end else begin
      wr_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_commit) mem[p_addr] <= p_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      dout_en <= rd_now;
      if (rd_now) dout <= mem[addr];
    end
  end
endmodule

// File: rtl/pfc_sram_guard.sv
module pfc_sram_guard #(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int DESEL_CYC   = 2500,
  parameter int RECOV_CYC   = 125000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              pfi_n
);
  logic pg_sync, bus_ok, locked, wr_commit, wr_pend;

  pfc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pwr_good), .q(pg_sync)
  );

  pfc_seq #(.DESEL_CYC(DESEL_CYC), .RECOV_CYC(RECOV_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .pg(pg_sync),
    .bus_ok(bus_ok), .locked(locked), .pfi_n(pfi_n)
  );

  pfc_array #(.AW(ADDR_W), .DW(DATA_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .bus_ok(bus_ok),
    .ce1_n(ce1_n), .ce2(ce2), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .wr_commit(wr_commit), .wr_pend(wr_pend)
  );
endmodule

// File: rtl/pfc_sram_guard_chk.sv
module pfc_sram_guard_chk #(
  parameter int DESEL_CYC = 2500
) (
  input logic clk,
  input logic rst_n,
  input logic ce1_n,
  input logic ce2,
  input logic oe_n,
  input logic we_n,
  input logic dout_en,
  input logic pfi_n,
  input logic bus_ok,
  input logic locked,
  input logic wr_commit,
  input logic wr_pend
);
  int warn_cnt;
  logic warn;

  assign warn = !pfi_n && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    warn_cnt <= 0;
    else if (warn) warn_cnt <= warn_cnt + 1;
    else           warn_cnt <= 0;
  end

  p_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce1_n || !ce2) |=> !dout_en);

  p_no_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n || !we_n) |=> !dout_en);

  p_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(locked) && !$past(pfi_n)) |-> (warn_cnt == DESEL_CYC));

  p_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ok |=> !dout_en);

  p_no_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ok |-> !wr_commit);

  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> !wr_pend);

  p_irq_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ok && !locked) |-> pfi_n);
endmodule

bind pfc_sram_guard pfc_sram_guard_chk #(.DESEL_CYC(DESEL_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .oe_n(oe_n),
  .we_n(we_n), .dout_en(dout_en), .pfi_n(pfi_n), .bus_ok(bus_ok),
  .locked(locked), .wr_commit(wr_commit), .wr_pend(wr_pend)
);

// File: tb/sim_pfc_sram_guard.sv
module sim_pfc_sram_guard;
  localparam int AW = 6;
  localparam int D  = 8;
  localparam int R  = 12;

  logic clk = 1'b0, rst_n = 1'b0, pwr_good = 1'b1;
  logic ce1_n = 1'b1, ce2 = 1'b0, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_en, pfi_n;

  int checks = 0, errors = 0;
  string cur_req = "R9";
  bit done = 0;

  always #4 clk = ~clk;

  pfc_sram_guard #(.ADDR_W(AW), .DATA_W(8), .DESEL_CYC(D), .RECOV_CYC(R)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .ce1_n(ce1_n), .ce2(ce2),
    .oe_n(oe_n), .we_n(we_n), .addr(addr), .din(din), .dout(dout),
    .dout_en(dout_en), .pfi_n(pfi_n)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: 0 run, 1 warn, 2 lock, 3 recover
  int m_st, m_cnt, m_paddr, m_pdata, m_d;
  bit m_s1, m_s2, m_pend, m_en, m_known;
  logic [7:0] mm [int];

  always @(posedge clk) begin
    bit ok, wr, rd;
    if (!rst_n) begin
      m_st = 3; m_cnt = 0; m_s1 = 1; m_s2 = 1; m_pend = 0; m_en = 0;
    end else begin
      ok = (m_st == 0) || (m_st == 1);
      wr = !ce1_n && ce2 && !we_n;
      rd = ok && !ce1_n && ce2 && we_n && !oe_n;
      m_en = rd;
      if (rd) begin
        m_known = mm.exists(int'(addr));
        if (m_known) m_d = int'(mm[int'(addr)]);
      end
      if (ok && m_pend && !wr) mm[m_paddr] = 8'(m_pdata);
      if (ok && wr) begin
        m_pend = 1; m_paddr = int'(addr); m_pdata = int'(din);
      end else m_pend = 0;
      case (m_st)
        0: if (!m_s2) begin m_st = 1; m_cnt = 0; end
        1: if (m_s2) begin m_st = 3; m_cnt = 0; end
           else if (m_cnt == D - 1) begin m_st = 2; m_cnt = 0; end
           else m_cnt++;
        2: if (m_s2) begin m_st = 3; m_cnt = 0; end
        default: if (!m_s2) begin m_st = 2; m_cnt = 0; end
           else if (m_cnt == R - 1) begin m_st = 0; m_cnt = 0; end
           else m_cnt++;
      endcase
      m_s2 = m_s1;
      m_s1 = pwr_good;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk(cur_req, "pfi_n vs model", int'(pfi_n), (m_st == 1 || m_st == 2) ? 0 : 1);
      chk(cur_req, "dout_en vs model", int'(dout_en), int'(m_en));
      if (m_en && m_known) chk(cur_req, "dout vs model", int'(dout), m_d);
    end
  end

  task automatic idle();
    ce1_n = 1; ce2 = 0; we_n = 1; oe_n = 1;
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); ce1_n = 0; ce2 = 1; we_n = 0; oe_n = 0;
    addr = AW'(a); din = 8'(d);
    @(negedge clk); idle();
  endtask

  task automatic rd(int a, int exp_en, int exp_d, string req);
    @(negedge clk); ce1_n = 0; ce2 = 1; we_n = 1; oe_n = 0; addr = AW'(a);
    @(negedge clk);
    chk(req, "read enable", int'(dout_en), exp_en);
    if (exp_en != 0) chk(req, "read data", int'(dout), exp_d);
    idle();
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R9", "pfi_n in reset", int'(pfi_n), 1);
    chk("R9", "dout_en in reset", int'(dout_en), 0);
    rst_n = 1;
    rd(1, 0, 0, "R9");
    repeat (R + 2) @(negedge clk);

    cur_req = "R2";
    wr(1, 8'h11); wr(2, 8'h22); wr(3, 8'h33); wr(4, 8'h44);
    rd(1, 1, 8'h11, "R2"); rd(4, 1, 8'h44, "R3");
    // long pulse with changing data: last sample wins
    @(negedge clk); ce1_n = 0; ce2 = 1; we_n = 0; oe_n = 1; addr = 5; din = 8'h50;
    @(negedge clk); din = 8'h51;
    @(negedge clk); din = 8'h5A;
    @(negedge clk); idle();
    rd(5, 1, 8'h5A, "R2");

    cur_req = "R3";
    @(negedge clk); ce1_n = 0; ce2 = 1; we_n = 1; oe_n = 1; addr = 2;
    @(negedge clk); chk("R3", "oe_n high no drive", int'(dout_en), 0); idle();

    cur_req = "R1";
    @(negedge clk); ce1_n = 1; ce2 = 1; we_n = 0; oe_n = 0; addr = 2; din = 8'hEE;
    @(negedge clk); ce1_n = 0; ce2 = 0;
    @(negedge clk); chk("R1", "deselect no drive", int'(dout_en), 0); idle();
    repeat (2) @(negedge clk);
    rd(2, 1, 8'h22, "R1");

    // power fail: synchroniser latency and warning window
    cur_req = "R4";
    @(negedge clk); pwr_good = 0; n = 0;
    for (int i = 0; i < 10 && pfi_n; i++) begin @(negedge clk); n++; end
    chk("R4", "edges to pfi_n low", n, 3);
    cur_req = "R5";
    ce1_n = 0; ce2 = 1; we_n = 1; oe_n = 0; addr = 3; n = 0;
    for (int i = 0; i < 2 * D + 4; i++) begin
      @(negedge clk);
      if (dout_en) n++;
    end
    chk("R5", "served edges after pfi_n", n, D);
    idle();

    cur_req = "R6";
    wr(3, 8'hBB);
    rd(3, 0, 0, "R6");
    chk("R6", "pfi_n low while locked", int'(pfi_n), 0);

    cur_req = "R8";
    @(negedge clk); pwr_good = 1;
    for (int i = 0; i < 10 && !pfi_n; i++) @(negedge clk);
    ce1_n = 0; ce2 = 1; we_n = 1; oe_n = 0; addr = 3; n = 0;
    for (int i = 0; i < 3 * R && !dout_en; i++) begin @(negedge clk); if (!dout_en) n++; end
    chk("R8", "blocked edges in recovery", n, R);
    chk("R6", "locked write ignored", int'(dout), 8'h33);
    idle();

    // write held across lockout is discarded
    cur_req = "R7";
    @(negedge clk); pwr_good = 0;
    for (int i = 0; i < 10 && pfi_n; i++) @(negedge clk);
    ce1_n = 0; ce2 = 1; we_n = 0; addr = 4; din = 8'hC7;
    repeat (D + 4) @(negedge clk);
    idle();
    @(negedge clk); pwr_good = 1;
    repeat (R + 6) @(negedge clk);
    rd(4, 1, 8'h44, "R7");

    // glitch during warning goes to recovery
    cur_req = "R10";
    @(negedge clk); pwr_good = 0;
    for (int i = 0; i < 10 && pfi_n; i++) @(negedge clk);
    pwr_good = 1;
    repeat (4) @(negedge clk);
    chk("R10", "pfi_n released after glitch", int'(pfi_n), 1);
    rd(1, 0, 0, "R10");
    // failure during recovery locks at once
    @(negedge clk); pwr_good = 0;
    repeat (3) @(negedge clk);
    chk("R10", "pfi_n low from recovery", int'(pfi_n), 0);
    rd(1, 0, 0, "R10");
    @(negedge clk); pwr_good = 1;
    repeat (R + 6) @(negedge clk);
    rd(1, 1, 8'h11, "R10");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule